// File: doc/BRIEF.md
# I2C Automatic Clock-Stretch Controller

This block decides when an I2C controller must hold SCL low because its own FIFO cannot keep up, and it bounds that hold with a programmable timeout so that a stalled FIFO cannot freeze the bus. It has two independent channels: index 0 serves the master role and index 1 serves the slave role. Each channel has its own 4-bit mode code, its own direction and byte-phase inputs, its own FIFO flags, and its own sticky timeout flag.

The block watches the sampled SCL line. On a qualifying SCL falling edge it raises the channel's hold request. A transmitter stretches when its Tx FIFO is empty. A receiver stretches when its Rx FIFO is full. The hold ends when the FIFO condition clears, or when the timeout runs out. The timeout is measured in clk cycles from a two-byte divider setting, scaled by a power of two that the mode code selects. It therefore does not depend on the SCL rate. A single read strobe clears both timeout flags.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: Mode code 0 disables a channel. Its hold request stays low whatever the FIFO flags, direction and phase are. Setting code 0 during a hold releases it on the next clock.
- R2: A transmitting channel (`is_tx`=1) starts a hold on an SCL falling edge when `tx_empty` is 1 and `phase` is 1 (acknowledge slot next) or 2 (data byte next). It does not start a hold when `tx_empty` is 0 or `phase` is 0.
- R3: A receiving channel (`is_tx`=0) starts a hold on an SCL falling edge only when `rx_full` is 1 and `phase` is 1. Phase 2 or phase 0 never starts a receive hold.
- R4: For codes 1 to 14, a hold whose FIFO condition stays true lasts exactly (div_hi + div_lo + 1) × 2^code clk cycles. The count starts from zero at every new hold.
- R5: Code 15 never times out. The hold lasts as long as the FIFO condition stays true.
- R6: When the FIFO condition that started the hold clears, the hold request drops at the next rising clk edge.
- R7: After a timeout the channel keeps its hold low, even if the FIFO condition persists, until the next qualifying SCL falling edge.
- R8: A timeout sets the channel's `tmo_flag` at the same edge that releases the hold. The flag stays set until a read.
- R9: A one-cycle `stat_rd` clears both flags at the next edge. If a timeout and a read fall in the same cycle, the flag ends up set.
- R10: The two channels are independent. Activity, holds and timeouts on one channel do not change the other channel's hold or flag.
- R11: When SCL is first sampled low at rising edge k, with SCL high for at least three edges before that, the hold request of a qualifying channel is high after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (divided core clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL bus line, asynchronous |
| div_hi | input | 8 | Divider high byte |
| div_lo | input | 8 | Divider low byte |
| stat_rd | input | 1 | Status read strobe; clears both flags |
| mode | input | NCH×4 | Per-channel mode code (0 = off, 1..14 = timed, 15 = untimed) |
| is_tx | input | NCH | Per-channel direction, 1 = transmitter |
| phase | input | NCH×2 | Per-channel byte phase: 0 = none, 1 = ack slot next, 2 = data byte next |
| tx_empty | input | NCH | Per-channel Tx FIFO empty flag |
| rx_full | input | NCH | Per-channel Rx FIFO full flag |
| hold_scl | output | NCH | Per-channel request to hold SCL low |
| tmo_flag | output | NCH | Per-channel sticky timeout flag |

## Verification
Timed codes 1 to 6 are swept over three divider pairs on the master channel, and codes 1 to 3 on the slave channel. One long code-14 run is added. Each hold's length is compared with the product computed in the bench, which separates errors in the base sum from errors in the shift. Trigger patterns cover every combination of direction, phase and FIFO flag. These show which points in a byte actually start a stretch. Further runs cover an untimed hold that ends when the FIFO is refilled, re-triggering after a timeout, and a read that lands exactly on the timeout edge. These runs separate release by FIFO from release by timeout, and they show the priority between setting and clearing the flag.

// File: rtl/stretch_pkg.sv
package stretch_pkg;
  localparam int DIV_W  = 8;
  localparam int CODE_W = 4;
  localparam int CNT_W  = DIV_W + 1 + (1 << CODE_W) - 1;

  localparam logic [CODE_W-1:0] CODE_OFF     = '0;
  localparam logic [CODE_W-1:0] CODE_FOREVER = '1;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ACK  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // hold length in clk cycles for a timed code
  function automatic logic [CNT_W-1:0] stretch_limit(
    input logic [DIV_W-1:0]  hi,
    input logic [DIV_W-1:0]  lo,
    input logic [CODE_W-1:0] code
  );
    logic [CNT_W-1:0] base;
    base = CNT_W'(hi) + CNT_W'(lo) + CNT_W'(1);
    return base << code;
  endfunction

  // does this falling edge start a stretch
  function automatic logic stretch_trigger(
    input logic   tx,
    input phase_e ph,
    input logic   txe,
    input logic   rxf
  );
    if (tx) return txe && (ph == PH_ACK || ph == PH_DATA);
    return rxf && (ph == PH_ACK);
  endfunction
endpackage

// File: rtl/scl_fall_det.sv
module scl_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_async,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], scl_async};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/stretch_chan.sv
module stretch_chan
  import stretch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_fall,
  input  logic [DIV_W-1:0]  div_hi,
  input  logic [DIV_W-1:0]  div_lo,
  input  logic [CODE_W-1:0] code,
  input  logic              is_tx,
  input  phase_e            phase,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              stat_rd,
  output logic              hold,
  output logic              flag,
  output logic              start_ev,
  output logic              tmo_ev,
  output logic              release_ev
);
  logic [CNT_W-1:0] cnt_q;
  logic             sel_tx_q;
  logic             cond;
  logic             timed;
  logic [CNT_W-1:0] limit;

  assign limit    = stretch_limit(div_hi, div_lo, code);
  assign timed    = (code != CODE_OFF) && (code != CODE_FOREVER);
  assign cond     = sel_tx_q ? tx_empty : rx_full;
  assign start_ev = scl_fall && (code != CODE_OFF) &&
                    stretch_trigger(is_tx, phase, tx_empty, rx_full);
  assign release_ev = hold && !start_ev && ((code == CODE_OFF) || !cond);
  assign tmo_ev   = hold && !start_ev && !release_ev && timed &&
                    (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= 1'b0;
      cnt_q    <= '0;
      sel_tx_q <= 1'b0;
    end else if (start_ev) begin
      hold     <= 1'b1;
      cnt_q    <= '0;
      sel_tx_q <= is_tx;
    end else if (hold) begin
      if (release_ev || tmo_ev) hold <= 1'b0;
      else                      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (tmo_ev)  flag <= 1'b1;
    else if (stat_rd) flag <= 1'b0;
  end
endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl
  import stretch_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic [DIV_W-1:0]           div_hi,
  input  logic [DIV_W-1:0]           div_lo,
  input  logic                       stat_rd,
  input  logic [NCH-1:0][CODE_W-1:0] mode,
  input  logic [NCH-1:0]             is_tx,
  input  logic [NCH-1:0][1:0]        phase,
  input  logic [NCH-1:0]             tx_empty,
  input  logic [NCH-1:0]             rx_full,
  output logic [NCH-1:0]             hold_scl,
  output logic [NCH-1:0]             tmo_flag
);
  logic           scl_fall;
  logic [NCH-1:0] start_ev;
  logic [NCH-1:0] tmo_ev;
  logic [NCH-1:0] release_ev;

  scl_fall_det #(.SYNC_STAGES(2)) u_fall (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_async (scl_in),
    .fall      (scl_fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    stretch_chan u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_fall   (scl_fall),
      .div_hi     (div_hi),
      .div_lo     (div_lo),
      .code       (mode[c]),
      .is_tx      (is_tx[c]),
      .phase      (phase_e'(phase[c])),
      .tx_empty   (tx_empty[c]),
      .rx_full    (rx_full[c]),
      .stat_rd    (stat_rd),
      .hold       (hold_scl[c]),
      .flag       (tmo_flag[c]),
      .start_ev   (start_ev[c]),
      .tmo_ev     (tmo_ev[c]),
      .release_ev (release_ev[c])
    );
  end
endmodule

// File: rtl/stretch_ctrl_chk.sv
module stretch_ctrl_chk #(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 stat_rd,
  input logic [NCH-1:0][3:0]  mode,
  input logic [NCH-1:0]       tx_empty,
  input logic [NCH-1:0]       rx_full,
  input logic [NCH-1:0]       hold_scl,
  input logic [NCH-1:0]       tmo_flag,
  input logic                 scl_fall,
  input logic [NCH-1:0]       tmo_ev
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R1
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[c] == 4'd0 |=> !hold_scl[c]);
    // R11
    rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_scl[c]) |-> $past(scl_fall));
    // R5
    forever_no_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[c] == 4'd15 |-> !tmo_ev[c]);
    // R6
    cond_gone_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_scl[c] && !tx_empty[c] && !rx_full[c] && !scl_fall) |=> !hold_scl[c]);
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_ev[c] |=> (tmo_flag[c] && !hold_scl[c]));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag[c] && !stat_rd) |=> tmo_flag[c]);
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tmo_ev[c]) |=> !tmo_flag[c]);
  end
endmodule

bind i2c_stretch_ctrl stretch_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stat_rd  (stat_rd),
  .mode     (mode),
  .tx_empty (tx_empty),
  .rx_full  (rx_full),
  .hold_scl (hold_scl),
  .tmo_flag (tmo_flag),
  .scl_fall (scl_fall),
  .tmo_ev   (tmo_ev)
);

// File: tb/tb_i2c_stretch_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_stretch_ctrl;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1;
  logic [7:0] div_hi = '0, div_lo = '0;
  logic stat_rd = 1'b0;
  logic [NCH-1:0][3:0] mode = '0;
  logic [NCH-1:0] is_tx = '0;
  logic [NCH-1:0][1:0] phase = '0;
  logic [NCH-1:0] tx_empty = '0, rx_full = '0;
  logic [NCH-1:0] hold_scl, tmo_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  i2c_stretch_ctrl #(.NCH(NCH)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drop SCL, measure latency to hold and hold duration on channel ch
  task automatic run(input int ch, output int lat, output int dur);
    scl_in = 1'b1;
    repeat (4) @(negedge clk);
    scl_in = 1'b0;
    lat = 0;
    while (!hold_scl[ch] && lat < 8) begin @(negedge clk); lat++; end
    dur = 0;
    while (hold_scl[ch] && dur < 40000) begin @(negedge clk); dur++; end
    scl_in = 1'b1;
  endtask

  task automatic read_pulse();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, dur;
    repeat (3) @(negedge clk);
    chk("reset hold", int'(hold_scl), 0);
    chk("reset flag", int'(tmo_flag), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: disabled channel, all triggers present
    is_tx = 2'b11; tx_empty = 2'b11; phase[0] = 2'd1; phase[1] = 2'd1;
    run(0, lat, dur);
    chk("R1 code0 master no hold", dur + (lat == 8 ? 0 : 1), 0);
    chk("R1 code0 slave no hold", int'(hold_scl[1]), 0);

    // R4 + R11 + R8 + R9: master sweep, tx data phase
    phase[0] = 2'd2;
    for (int d = 0; d < 3; d++) begin
      div_hi = (d == 0) ? 8'd0 : (d == 1) ? 8'd1 : 8'd3;
      div_lo = (d == 0) ? 8'd0 : (d == 1) ? 8'd2 : 8'd0;
      for (int code = 1; code <= 6; code++) begin
        mode[0] = 4'(code);
        run(0, lat, dur);
        chk("R11 latency", lat, 3);
        chk("R4 timed length", dur, (int'(div_hi) + int'(div_lo) + 1) << code);
        chk("R8 flag after timeout", int'(tmo_flag[0]), 1);
        chk("R10 slave untouched", int'(tmo_flag[1]), 0);
        read_pulse();
        chk("R9 read clears", int'(tmo_flag[0]), 0);
      end
    end

    // R4 long code 14
    div_hi = 0; div_lo = 0; mode[0] = 4'd14;
    run(0, lat, dur);
    chk("R4 code14 length", dur, 16384);
    read_pulse();

    // R7: condition persists, no new hold without new fall
    repeat (50) @(negedge clk);
    chk("R7 no restretch", int'(hold_scl[0]), 0);
    mode[0] = 4'd2;
    run(0, lat, dur);
    chk("R7 new fall restretches", dur, 4);
    read_pulse();

    // R2 negatives
    tx_empty[0] = 1'b0;
    run(0, lat, dur);
    chk("R2 tx not empty no hold", lat, 8);
    tx_empty[0] = 1'b1; phase[0] = 2'd0;
    run(0, lat, dur);
    chk("R2 phase none no hold", lat, 8);
    phase[0] = 2'd1;
    run(0, lat, dur);
    chk("R2 ack phase tx length", dur, 4);
    read_pulse();

    // R3 receive
    is_tx[0] = 1'b0; tx_empty[0] = 1'b0; rx_full[0] = 1'b1; phase[0] = 2'd2;
    run(0, lat, dur);
    chk("R3 rx data phase no hold", lat, 8);
    phase[0] = 2'd1;
    run(0, lat, dur);
    chk("R3 rx ack phase length", dur, 4);
    read_pulse();
    rx_full[0] = 1'b0;
    run(0, lat, dur);
    chk("R3 rx not full no hold", lat, 8);

    // R5 + R6: untimed hold released by refill
    is_tx[0] = 1'b1; tx_empty[0] = 1'b1; mode[0] = 4'd15;
    scl_in = 1'b1; repeat (4) @(negedge clk);
    scl_in = 1'b0; repeat (3) @(negedge clk);
    chk("R5 hold started", int'(hold_scl[0]), 1);
    repeat (300) @(negedge clk);
    chk("R5 still holding", int'(hold_scl[0]), 1);
    chk("R5 no flag", int'(tmo_flag[0]), 0);
    tx_empty[0] = 1'b0;
    @(negedge clk);
    chk("R6 release next edge", int'(hold_scl[0]), 0);
    scl_in = 1'b1;

    // R1: code 0 mid-hold releases
    tx_empty[0] = 1'b1;
    scl_in = 1'b1; repeat (4) @(negedge clk);
    scl_in = 1'b0; repeat (3) @(negedge clk);
    mode[0] = 4'd0;
    @(negedge clk);
    chk("R1 code0 releases", int'(hold_scl[0]), 0);
    scl_in = 1'b1;

    // R9: timeout and read in same cycle, set wins
    mode[0] = 4'd2;
    scl_in = 1'b1; repeat (4) @(negedge clk);
    scl_in = 1'b0; repeat (3) @(negedge clk);
    repeat (3) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R9 timed out", int'(hold_scl[0]), 0);
    chk("R9 set wins", int'(tmo_flag[0]), 1);
    read_pulse();
    chk("R9 later read clears", int'(tmo_flag[0]), 0);
    scl_in = 1'b1;

    // R10: slave channel sweep, master disabled
    mode[0] = 4'd0;
    is_tx[1] = 1'b0; rx_full[1] = 1'b1; tx_empty[1] = 1'b0; phase[1] = 2'd1;
    div_hi = 8'd2; div_lo = 8'd1;
    for (int code = 1; code <= 3; code++) begin
      mode[1] = 4'(code);
      run(1, lat, dur);
      chk("R4 slave length", dur, 4 << code);
      chk("R10 master flag clear", int'(tmo_flag[0]), 0);
      chk("R10 master no hold", int'(hold_scl[0]), 0);
      chk("R8 slave flag", int'(tmo_flag[1]), 1);
      read_pulse();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule